// File: doc/BRIEF.md
# Serial RAM-Write Command Decoder

This block is the receive side of a write-only three-wire serial link (active-low enable, data, serial clock) that fills an 11-row by 32-column byte RAM holding display control. A host holds the enable low for a transfer and clocks bytes in most significant bit first. The decoder assembles each byte and decides from its position in the current sequence what it is: a row address, a column address that opens single writes (format A), a column address that opens a streaming burst (format B), or a data byte. For every data byte it issues a one-cycle write strobe with row, column and data for the RAM, which lives outside the block.

The serial pins are brought into the system clock domain through a synchronizer, and the rising serial clock edge is found by comparing successive samples. A sequence state machine has the states ST_ROW (expect row address), ST_COL (expect column address), ST_DATA (expect the data byte after a format-A column), ST_ADDR (after such a data byte, expect a row or a format-A column), ST_STREAM (every byte is data) and ST_ERR (sticky fault). Its transitions are: ST_ROW to ST_COL on a valid row; ST_COL to ST_DATA on format A, to ST_STREAM on format B; ST_DATA to ST_ADDR on any byte; ST_ADDR to ST_COL on a valid row, to ST_DATA on format A; ST_STREAM to itself. Every other byte moves the machine to ST_ERR. Releasing the enable returns any state to ST_ROW.

Single writes between rows, repeated column/data pairs in one row, and streaming bursts may be mixed within one transfer as long as a burst is the last thing in it. A burst steps the column after each byte and carries into the next row after column 31; single writes also step the column, wrapping within the row.

Top module: `ramwr_serial_decoder`

## Requirements
- R1: After reset, wr_en and seq_err are 0.
- R2: While ser_en_n is low, ser_din is taken on each rising edge of ser_clk, eight bits make one byte, most significant bit first. Byte codes: bit 7 = 0 is a row address with the row in bits 3..0; bit 7 = 1 is a column address with the column in bits 4..0, bit 6 = 0 selecting format A and bit 6 = 1 format B.
- R3: A row address, a format-A column and one data byte produce exactly one write of that byte at that row and column; this may repeat from a new row within one transfer.
- R4: After a data byte of a format-A pair, a further format-A column followed by a data byte writes in the same row at the new column.
- R5: After a row and a format-B column, each following byte is written at successive columns of that row.
- R6: In a burst, the byte after one written at column 31 goes to column 0 of the next row; bytes that would fall beyond row 10 are dropped without a write.
- R7: Once a burst has started, bytes that look like row or column addresses are written as data.
- R8: A first byte that is not a row address, a row above 10, a row address where a column is expected, or a format-B column directly after a data byte, sets seq_err; it stays set and no write occurs until ser_en_n goes high.
- R9: When ser_en_n goes high, a partial byte is discarded, seq_err clears, and the next transfer starts by expecting a row address.
- R10: Within one transfer, single writes may be followed by pairs in one row, pairs by a new row, and either by a new row that opens a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_n | input | 1 | Serial transfer enable, active low |
| ser_clk | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_din | input | 1 | Serial data, most significant bit first |
| wr_en | output | 1 | One-cycle RAM write strobe |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 5 | Column of the write |
| wr_data | output | 8 | Byte to write |
| seq_err | output | 1 | Sequence fault, held until enable is released |

## Verification
On every cycle the assertions check that a write never coincides with a fault, that a write always follows an assembled byte, that no write names a row past the last one, that a fault holds through the transfer and is gone once the enable is released, and that assembled bytes only appear inside a transfer. Which row and column each byte lands at, the column-to-row carry at the end of a burst, the drop past row 10, the treatment of address-looking bytes as burst data and the discarding of a partial byte can only be shown by the bench's scenarios, which compare logged writes against arithmetic expectations, including a burst that sweeps the whole RAM.

// File: rtl/ramwr_pkg.sv
package ramwr_pkg;

    typedef enum logic [2:0] {
        ST_ROW,
        ST_COL,
        ST_DATA,
        ST_ADDR,
        ST_STREAM,
        ST_ERR
    } seq_state_t;

    typedef enum logic [1:0] {
        BK_ROW,
        BK_COLA,
        BK_COLB
    } byte_kind_t;

    function automatic byte_kind_t classify(input logic [7:0] b);
        if (!b[7])
            return BK_ROW;
        else if (!b[6])
            return BK_COLA;
        else
            return BK_COLB;
    endfunction

endpackage

// File: rtl/ramwr_deser.sv
module ramwr_deser #(
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          sck,
    input  logic          sdi,
    output logic          active,
    output logic          byte_vld,
    output logic [DW-1:0] byte_q
);
    localparam int CNT_W = $clog2(DW);

    logic [SYNC_STAGES-1:0] en_sync;
    logic [SYNC_STAGES-1:0] sck_sync;
    logic [SYNC_STAGES-1:0] sdi_sync;
    logic                   en_s, sck_s, sdi_s, sck_prev, rise;
    logic [DW-1:0]          shreg;
    logic [CNT_W-1:0]       bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_sync  <= '1;
            sck_sync <= '0;
            sdi_sync <= '0;
        end else begin
            en_sync  <= {en_sync[SYNC_STAGES-2:0], en_n};
            sck_sync <= {sck_sync[SYNC_STAGES-2:0], sck};
            sdi_sync <= {sdi_sync[SYNC_STAGES-2:0], sdi};
        end
    end

    assign en_s   = en_sync[SYNC_STAGES-1];
    assign sck_s  = sck_sync[SYNC_STAGES-1];
    assign sdi_s  = sdi_sync[SYNC_STAGES-1];
    assign rise   = sck_s & ~sck_prev;
    assign active = ~en_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            shreg    <= '0;
            bit_cnt  <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_vld <= 1'b0;
            sck_prev <= sck_s;
            if (en_s) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= {shreg[DW-2:0], sdi_s};
                if (bit_cnt == CNT_W'(DW - 1)) begin
                    bit_cnt  <= '0;
                    byte_vld <= 1'b1;
                    byte_q   <= {shreg[DW-2:0], sdi_s};
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end

    // R9
    vld_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(active));

    // R2
    vld_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

endmodule

// File: rtl/ramwr_seq.sv
module ramwr_seq
    import ramwr_pkg::*;
#(
    parameter int ROWS = 11,
    parameter int COLS = 32,
    parameter int DW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     active,
    input  logic                     byte_vld,
    input  logic [DW-1:0]            byte_in,
    output logic                     wr_en,
    output logic [$clog2(ROWS+1)-1:0] wr_row,
    output logic [$clog2(COLS)-1:0]   wr_col,
    output logic [DW-1:0]            wr_data,
    output logic                     seq_err
);
    localparam int ROW_W = $clog2(ROWS + 1);
    localparam int COL_W = $clog2(COLS);

    seq_state_t       st, nxt;
    byte_kind_t       kind;
    logic [ROW_W-1:0] row_ptr, row_fld;
    logic [COL_W-1:0] col_ptr, col_fld, col_step;
    logic             row_ok, col_last;

    assign kind     = classify(byte_in);
    assign row_fld  = byte_in[ROW_W-1:0];
    assign col_fld  = byte_in[COL_W-1:0];
    assign row_ok   = (kind == BK_ROW) && (row_fld < ROW_W'(ROWS));
    assign col_last = (col_ptr == COL_W'(COLS - 1));
    assign col_step = col_last ? '0 : col_ptr + COL_W'(1);
    assign seq_err  = (st == ST_ERR);

    always_comb begin
        nxt = st;
        if (!active) begin
            nxt = ST_ROW;
        end else if (byte_vld) begin
            unique case (st)
                ST_ROW:    nxt = row_ok ? ST_COL : ST_ERR;
                ST_COL:    nxt = (kind == BK_COLA) ? ST_DATA :
                                 (kind == BK_COLB) ? ST_STREAM : ST_ERR;
                ST_DATA:   nxt = ST_ADDR;
                ST_ADDR:   nxt = row_ok ? ST_COL :
                                 (kind == BK_COLA) ? ST_DATA : ST_ERR;
                ST_STREAM: nxt = ST_STREAM;
                default:   nxt = ST_ERR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_ROW;
        else
            st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_row  <= '0;
            wr_col  <= '0;
            wr_data <= '0;
            row_ptr <= '0;
            col_ptr <= '0;
        end else begin
            wr_en <= 1'b0;
            if (active && byte_vld) begin
                unique case (st)
                    ST_ROW, ST_ADDR: begin
                        if (kind == BK_ROW)
                            row_ptr <= row_fld;
                        else if (kind == BK_COLA)
                            col_ptr <= col_fld;
                    end
                    ST_COL: begin
                        if (kind != BK_ROW)
                            col_ptr <= col_fld;
                    end
                    ST_DATA: begin
                        wr_en   <= 1'b1;
                        wr_row  <= row_ptr;
                        wr_col  <= col_ptr;
                        wr_data <= byte_in;
                        col_ptr <= col_step;
                    end
                    ST_STREAM: begin
                        if (row_ptr < ROW_W'(ROWS)) begin
                            wr_en   <= 1'b1;
                            wr_row  <= row_ptr;
                            wr_col  <= col_ptr;
                            wr_data <= byte_in;
                            col_ptr <= col_step;
                            if (col_last)
                                row_ptr <= row_ptr + ROW_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8
    no_write_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> !wr_en);

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && active) |=> seq_err);

    // R9
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !seq_err);

    // R6
    row_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_row < ROW_W'(ROWS)));

    // R3
    write_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(byte_vld));

endmodule

// File: rtl/ramwr_serial_decoder.sv
module ramwr_serial_decoder #(
    parameter int ROWS        = 11,
    parameter int COLS        = 32,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ser_en_n,
    input  logic                      ser_clk,
    input  logic                      ser_din,
    output logic                      wr_en,
    output logic [$clog2(ROWS+1)-1:0] wr_row,
    output logic [$clog2(COLS)-1:0]   wr_col,
    output logic [DW-1:0]             wr_data,
    output logic                      seq_err
);
    logic          active;
    logic          byte_vld;
    logic [DW-1:0] byte_q;

    ramwr_deser #(
        .SYNC_STAGES (SYNC_STAGES),
        .DW          (DW)
    ) i_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_n     (ser_en_n),
        .sck      (ser_clk),
        .sdi      (ser_din),
        .active   (active),
        .byte_vld (byte_vld),
        .byte_q   (byte_q)
    );

    ramwr_seq #(
        .ROWS (ROWS),
        .COLS (COLS),
        .DW   (DW)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .byte_vld (byte_vld),
        .byte_in  (byte_q),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_data  (wr_data),
        .seq_err  (seq_err)
    );

endmodule

// File: tb/test_ramwr_serial_decoder.sv
`timescale 1ns/1ps
module test_ramwr_serial_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_en_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       wr_en;
    logic [3:0] wr_row;
    logic [4:0] wr_col;
    logic [7:0] wr_data;
    logic       seq_err;

    int checks = 0;
    int errors = 0;
    int wcnt = 0;
    int base;
    bit done = 0;
    int lg_row [0:511];
    int lg_col [0:511];
    int lg_dat [0:511];

    always #4 clk = ~clk;

    ramwr_serial_decoder i_ramwr_serial_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_en_n (ser_en_n),
        .ser_clk  (ser_clk),
        .ser_din  (ser_din),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_data  (wr_data),
        .seq_err  (seq_err)
    );

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (wcnt < 512) begin
                lg_row[wcnt] = int'(wr_row);
                lg_col[wcnt] = int'(wr_col);
                lg_dat[wcnt] = int'(wr_data);
            end
            wcnt = wcnt + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk) ser_din = b;
        wait_clk(4);
        @(negedge clk) ser_clk = 1'b1;
        wait_clk(4);
        @(negedge clk) ser_clk = 1'b0;
        wait_clk(4);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic xfer_start();
        @(negedge clk) ser_en_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic xfer_stop();
        wait_clk(10);
        @(negedge clk) ser_en_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic exp_wr(input string tag, input int idx, input int r, input int c, input int d);
        chk({tag, " row"}, lg_row[idx], r);
        chk({tag, " col"}, lg_col[idx], c);
        chk({tag, " data"}, lg_dat[idx], d);
    endtask

    task automatic peek_err(input string tag, input int exp);
        wait_clk(4);
        @(negedge clk);
        chk(tag, int'(seq_err), exp);
    endtask

    function automatic logic [7:0] b_row(input int r);
        return {4'b0000, 4'(r)};
    endfunction

    function automatic logic [7:0] b_cola(input int c);
        return {3'b100, 5'(c)};
    endfunction

    function automatic logic [7:0] b_colb(input int c);
        return {3'b110, 5'(c)};
    endfunction

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        @(negedge clk);
        chk("R1 wr_en after reset", int'(wr_en), 0);
        chk("R1 seq_err after reset", int'(seq_err), 0);
        rst_n = 1'b1;
        wait_clk(4);

        // R3: single writes sweeping every row
        base = wcnt;
        xfer_start();
        for (int r = 0; r < 11; r++) begin
            send_byte(b_row(r));
            send_byte(b_cola((r * 3) % 32));
            send_byte(8'((r * 17 + 5) & 255));
        end
        xfer_stop();
        chk("R3 write count", wcnt - base, 11);
        for (int r = 0; r < 11; r++)
            exp_wr("R3 single write", base + r, r, (r * 3) % 32, (r * 17 + 5) & 255);

        // R4: column/data pairs in one row
        base = wcnt;
        xfer_start();
        send_byte(b_row(4));
        for (int k = 0; k < 7; k++) begin
            send_byte(b_cola(k * 5));
            send_byte(8'(k * 9 + 1));
        end
        xfer_stop();
        chk("R4 write count", wcnt - base, 7);
        for (int k = 0; k < 7; k++)
            exp_wr("R4 pair write", base + k, 4, k * 5, k * 9 + 1);

        // R10: single -> pair -> new row -> burst in one transfer
        base = wcnt;
        xfer_start();
        send_byte(b_row(1)); send_byte(b_cola(3)); send_byte(8'h11);
        send_byte(b_cola(7)); send_byte(8'h22);
        send_byte(b_row(9)); send_byte(b_cola(0)); send_byte(8'h33);
        send_byte(b_row(5)); send_byte(b_colb(30));
        send_byte(8'h44); send_byte(8'h55); send_byte(8'h66);
        xfer_stop();
        chk("R10 write count", wcnt - base, 6);
        exp_wr("R10 single", base + 0, 1, 3, 8'h11);
        exp_wr("R10 pair", base + 1, 1, 7, 8'h22);
        exp_wr("R10 new row", base + 2, 9, 0, 8'h33);
        exp_wr("R10 burst", base + 3, 5, 30, 8'h44);
        exp_wr("R10 burst", base + 4, 5, 31, 8'h55);
        exp_wr("R6 carry", base + 5, 6, 0, 8'h66);

        // R5 R6: burst filling the whole RAM, three extra bytes dropped
        base = wcnt;
        xfer_start();
        send_byte(b_row(0));
        send_byte(b_colb(0));
        for (int i = 0; i < 355; i++) send_byte(8'((i * 7 + 3) & 255));
        xfer_stop();
        chk("R6 burst write count", wcnt - base, 352);
        for (int i = 0; i < 352; i++)
            exp_wr("R5 burst sweep", base + i, i / 32, i % 32, (i * 7 + 3) & 255);

        // R7: address-looking bytes inside a burst are data
        base = wcnt;
        xfer_start();
        send_byte(b_row(2)); send_byte(b_colb(10));
        send_byte(8'h02); send_byte(8'hC1); send_byte(8'h8F);
        peek_err("R7 no fault in burst", 0);
        xfer_stop();
        chk("R7 write count", wcnt - base, 3);
        exp_wr("R7 row-like data", base + 0, 2, 10, 8'h02);
        exp_wr("R7 colb-like data", base + 1, 2, 11, 8'hC1);
        exp_wr("R7 cola-like data", base + 2, 2, 12, 8'h8F);

        // R8: column first
        base = wcnt;
        xfer_start();
        send_byte(b_cola(3));
        peek_err("R8 column first", 1);
        send_byte(b_row(1)); send_byte(b_cola(1)); send_byte(8'hAA);
        peek_err("R8 fault sticky", 1);
        chk("R8 writes blocked", wcnt - base, 0);
        xfer_stop();
        chk("R9 fault cleared", int'(seq_err), 0);

        // R8: row above 10
        xfer_start();
        send_byte(b_row(12));
        peek_err("R8 row out of range", 1);
        xfer_stop();

        // R8: row where column expected
        xfer_start();
        send_byte(b_row(1)); send_byte(b_row(2));
        peek_err("R8 row instead of column", 1);
        xfer_stop();

        // R8: format-B column directly after data
        base = wcnt;
        xfer_start();
        send_byte(b_row(3)); send_byte(b_cola(4)); send_byte(8'h77);
        peek_err("R8 before bad colb", 0);
        send_byte(b_colb(5)); send_byte(8'h88);
        peek_err("R8 colb after data", 1);
        xfer_stop();
        chk("R8 writes before fault only", wcnt - base, 1);
        exp_wr("R8 good write", base, 3, 4, 8'h77);

        // R9: partial byte discarded
        base = wcnt;
        xfer_start();
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        xfer_stop();
        xfer_start();
        send_byte(b_row(2)); send_byte(b_cola(5)); send_byte(8'h5A);
        xfer_stop();
        chk("R9 partial discarded count", wcnt - base, 1);
        exp_wr("R9 after partial", base, 2, 5, 8'h5A);

        // R9: sequence restarts at row address
        base = wcnt;
        xfer_start();
        send_byte(b_row(3)); send_byte(b_cola(6));
        xfer_stop();
        xfer_start();
        send_byte(8'h07); send_byte(b_cola(1)); send_byte(8'h99);
        xfer_stop();
        chk("R9 restart count", wcnt - base, 1);
        exp_wr("R9 restart", base, 7, 1, 8'h99);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule